// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of seven DMA channels may use the transfer bus next. Every channel has a request line from its peripheral, an enable, and a two-bit software level. When the bus is free, the arbiter picks the enabled, requesting channel with the highest level. A lower channel index breaks a tie between equal levels. The result is a registered one-hot grant, and the grant stays in place until the transfer datapath reports with a single-cycle done pulse that the data unit has moved.

Each grant also opens a four-phase handshake with the chosen peripheral. The acknowledge for that channel rises together with the grant. The peripheral then withdraws its request, and the arbiter removes the acknowledge in reply. A channel whose acknowledge is still high takes no part in arbitration, so the peripheral can only issue a new request after the previous handshake has closed. Address generation and data movement are handled elsewhere.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held low at a clock edge, `grant_o` and `ack_o` are all zero after that edge.
- R2: A channel competes only when its request is high, its enable is high and its acknowledge is low. A disabled channel is never granted, whatever its level.
- R3: The level of channel c is `prio_i[2c+1:2c]`, where 2'b11 is very high, 2'b10 high, 2'b01 medium and 2'b00 low. The competing channel with the highest level wins.
- R4: Among competing channels at the same level, the lowest channel index wins.
- R5: `grant_o` is one-hot or zero. When the bus is idle at an edge and at least one channel competes, the winner's grant bit is set after that edge.
- R6: A grant stays unchanged until an edge where `done_i` is high, and it is zero after that edge. A higher-level request that arrives during a grant does not pre-empt it.
- R7: A channel's `ack_o` bit rises at the same edge as its grant bit, and at no other time.
- R8: An acknowledge falls at the first edge where that channel's request is low. It stays high while the request stays high, including after done.
- R9: After a grant ends, a request held high with its acknowledge still set is not granted again. Once the acknowledge has dropped, a freshly raised request can win.
- R10: A `done_i` pulse while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 7 | Per-channel peripheral request |
| en_i | input | 7 | Per-channel enable |
| prio_i | input | 14 | Two-bit level per channel, channel c at bits [2c+1:2c] |
| done_i | input | 1 | One-cycle pulse: current data unit finished |
| grant_o | output | 7 | Registered one-hot bus grant |
| ack_o | output | 7 | Per-channel handshake acknowledge |

## Verification
Directed patterns cover the following cases:
- Two different levels requested at once, which tests level ordering separately from index ordering.
- Two channels at the same level, which tests the index tie-break on its own.
- A very-high channel that is disabled, which shows that the enable gates arbitration.
- A higher request that arrives in the middle of a grant, which separates a held grant from pre-emption.
- A request held high through done, and a done pulse while idle, which cover the handshake rules.

A seeded random phase then drives reactive peripherals that drop their requests after seeing the acknowledge at random delays. It also issues random done pulses and changes enables and levels. Every cycle is compared against a bench model of grant and acknowledge, which exposes ordering and handshake errors that only show up under overlapping traffic.

// File: rtl/dma_arb_pkg.sv
// Package: shared constants and level encoding for the DMA request arbiter.
// Assumes levels are compared as unsigned numbers, with a larger value meaning more urgent.
package dma_arb_pkg;

    localparam int ARB_NUM_CH = 7;
    localparam int ARB_PRIO_W = 2;

    typedef enum logic [ARB_PRIO_W-1:0] {
        LVL_LOW   = 2'b00,
        LVL_MED   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_VHIGH = 2'b11
    } arb_level_e;

endpackage

// File: rtl/dma_arb_pick.sv
// Module: combinational winner selection.
// Picks the eligible channel with the largest level; equal levels resolve to the
// lowest index. Assumes eligibility has already been qualified by enable and ack.
module dma_arb_pick #(
    parameter int NUM_CH = dma_arb_pkg::ARB_NUM_CH,
    parameter int PRIO_W = dma_arb_pkg::ARB_PRIO_W
) (
    input  logic [NUM_CH-1:0]        elig_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    output logic [NUM_CH-1:0]        win_o,
    output logic                     any_o
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [PRIO_W-1:0] lvl [NUM_CH];
    logic [PRIO_W-1:0] best_lvl;
    logic [IDX_W-1:0]  best_idx;
    logic              found;

    // Split the flat level bus into one field per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
        assign lvl[g] = prio_i[g*PRIO_W +: PRIO_W];
    end

    // Scan from the highest index downward; '>=' lets lower indices take ties.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        found    = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (elig_i[i] && (!found || lvl[i] >= best_lvl)) begin
                best_lvl = lvl[i];
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    // Expand the winning index to a one-hot vector.
    always_comb begin
        win_o = '0;
        if (found) win_o[best_idx] = 1'b1;
        any_o = found;
    end

endmodule

// File: rtl/dma_arb_ack_ch.sv
// Module: acknowledge flop for one channel's four-phase handshake.
// Raised when the channel is started; cleared once the peripheral's request is low.
// Assumes start_i is only pulsed while the acknowledge is low.
module dma_arb_ack_ch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic start_i,
    output logic ack_o
);
    // Handshake state: set on start, clear on request withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ack_o <= 1'b0;
        else if (start_i)           ack_o <= 1'b1;
        else if (ack_o && !req_i)   ack_o <= 1'b0;
    end

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !req_i) |=> !ack_o);

    // R8
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o);

endmodule

// File: rtl/dma_arb_grant.sv
// Module: registered bus grant.
// Loads the winner only while idle and holds it until the done pulse.
// Assumes win_i is one-hot or zero.
module dma_arb_grant #(
    parameter int NUM_CH = dma_arb_pkg::ARB_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] win_i,
    input  logic              any_i,
    input  logic              done_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] start_o
);
    logic idle;

    // Bus is idle when no grant is held; a new winner starts only then.
    always_comb begin
        idle    = (grant_o == '0);
        start_o = (idle && any_i) ? win_i : '0;
    end

    // Grant register: load while idle, release on done, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      grant_o <= '0;
        else if (idle)   grant_o <= start_o;
        else if (done_i) grant_o <= '0;
    end

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !done_i) |=> $stable(grant_o));

    // R6
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && done_i) |=> (grant_o == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
// Module: top of the DMA request arbiter.
// Qualifies requests by enable and handshake state, selects a winner by level
// and then index, registers a one-hot grant, and runs one ack flop per channel.
// Assumes done_i is a single-cycle pulse from the transfer datapath.
module dma_req_arbiter #(
    parameter int NUM_CH = dma_arb_pkg::ARB_NUM_CH,
    parameter int PRIO_W = dma_arb_pkg::ARB_PRIO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH*PRIO_W-1:0] prio_i,
    input  logic                     done_i,
    output logic [NUM_CH-1:0]        grant_o,
    output logic [NUM_CH-1:0]        ack_o
);
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] win;
    logic [NUM_CH-1:0] start;
    logic              any;

    // A channel competes only with request, enable and a closed handshake.
    always_comb elig = req_i & en_i & ~ack_o;

    dma_arb_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
        .elig_i (elig),
        .prio_i (prio_i),
        .win_o  (win),
        .any_o  (any)
    );

    dma_arb_grant #(.NUM_CH(NUM_CH)) u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win),
        .any_i   (any),
        .done_i  (done_i),
        .grant_o (grant_o),
        .start_o (start)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ack
        dma_arb_ack_ch u_ack (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_i[c]),
            .start_i (start[c]),
            .ack_o   (ack_o[c])
        );
    end

    // R7
    ack_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_o & ~$past(ack_o) & ~grant_o) == '0));

    // R2
    grant_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && $past(grant_o) == '0) |-> (($past(elig) & grant_o) != '0));

endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;
    localparam int NCH = 7;
    localparam int PW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]    req = '0;
    logic [NCH-1:0]    en = '0;
    logic [NCH*PW-1:0] prio = '0;
    logic              done = 1'b0;
    logic [NCH-1:0]    grant;
    logic [NCH-1:0]    ack;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en),
        .prio_i(prio), .done_i(done), .grant_o(grant), .ack_o(ack)
    );

    // Reference winner: scan levels from very high down, channels from 0 up.
    function automatic logic [NCH-1:0] ref_pick(logic [NCH-1:0] e, logic [NCH*PW-1:0] p);
        for (int l = 3; l >= 0; l--)
            for (int c = 0; c < NCH; c++)
                if (e[c] && p[c*PW +: PW] == l[PW-1:0]) return NCH'(1) << c;
        return '0;
    endfunction

    // Bench model of grant and acknowledge, built from the requirements.
    logic [NCH-1:0] m_g = '0;
    logic [NCH-1:0] m_a = '0;
    always @(posedge clk) begin
        logic [NCH-1:0] na, w;
        if (!rst_n) begin
            m_g <= '0; m_a <= '0;
        end else begin
            na = m_a & req;
            if (m_g == '0) begin
                w = ref_pick(req & en & ~m_a, prio);
                m_g <= w;
                na = na | w;
            end else if (done) begin
                m_g <= '0;
            end
            m_a <= na;
        end
    end

    task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_lvl(int ch, logic [1:0] l);
        prio[ch*PW +: PW] = l;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; en = '0; prio = '0; done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        rst_n = 1'b0; req = '1; en = '1; prio = '1;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", grant, '0);
        chk("R1 ack in reset", ack, '0);

        // R3 level ordering, R7 ack with grant, R6 no pre-emption, R8 ack drop
        apply_reset();
        en = '1; set_lvl(5, 2'b11); set_lvl(2, 2'b10); req = 7'b0100100;
        @(negedge clk);
        chk("R3 higher level wins", grant, 7'b0100000);
        chk("R7 ack rises with grant", ack, 7'b0100000);
        req[5] = 1'b0; set_lvl(0, 2'b11); req[0] = 1'b1;
        @(negedge clk);
        chk("R8 ack falls after request drop", ack, '0);
        chk("R6 grant held, no pre-emption", grant, 7'b0100000);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 grant released on done", grant, '0);
        @(negedge clk);
        chk("R3 next winner by level", grant, 7'b0000001);
        chk("R7 ack for next winner", ack, 7'b0000001);

        // R4 tie-break by index
        apply_reset();
        en = '1; set_lvl(1, 2'b01); set_lvl(4, 2'b01); req = 7'b0010010;
        @(negedge clk);
        chk("R4 equal level lower index wins", grant, 7'b0000010);

        // R2 disabled channel excluded, R9 re-request rules
        apply_reset();
        en = 7'b0111111; set_lvl(6, 2'b11); set_lvl(3, 2'b00); req = 7'b1001000;
        @(negedge clk);
        chk("R2 disabled very-high channel skipped", grant, 7'b0001000);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R6 released", grant, '0);
        @(negedge clk);
        chk("R9 held request with ack high not regranted", grant, '0);
        chk("R8 ack held while request high", ack, 7'b0001000);
        req[3] = 1'b0;
        @(negedge clk);
        chk("R8 ack closes", ack, '0);
        req[3] = 1'b1;
        @(negedge clk);
        chk("R9 new request after closure granted", grant, 7'b0001000);

        // R10 done while idle
        apply_reset();
        en = '1; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk("R10 idle done no grant", grant, '0);
        chk("R10 idle done no ack", ack, '0);
        req[2] = 1'b1;
        @(negedge clk);
        chk("R10 arbitration unaffected", grant, 7'b0000100);
        @(negedge clk);
        chk("R5 grant persists without done", grant, 7'b0000100);

        // Random phase against the bench model (R5, R8 and all ordering rules)
        apply_reset();
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            chk("R5 grant vs model", grant, m_g);
            chk("R8 ack vs model", ack, m_a);
            checks++;
            if ($countones(grant) > 1) begin
                fails++;
                $display("FAIL R5 onehot actual=%b expected=onehot0", grant);
            end
            if (n % 64 == 0) begin
                en = NCH'($urandom) | NCH'($urandom);
                prio = (NCH*PW)'($urandom);
            end
            for (int c = 0; c < NCH; c++) begin
                if (req[c] && ack[c]) begin
                    if ($urandom % 2 == 0) req[c] = 1'b0;
                end else if (!req[c] && !ack[c]) begin
                    if ($urandom % 4 == 0) req[c] = 1'b1;
                end
            end
            done = (grant != '0) ? ($urandom % 3 == 0) : ($urandom % 16 == 0);
        end
        done = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule